// File: doc/BRIEF.md
# Indirect register access window

This block lets a small I/O region of 64 bytes reach a larger bank of 32-bit device registers by indirection. The region holds two 32-bit ports. A full-width write to the address port stores a register byte offset. Later accesses to the data port then read or write the register that offset selects. Each register in the bank has its own access rule: writable, read-only, or absent.

The first word of the bank is a control register. Setting its reset bit returns the bank and the stored offset to their defaults in one clock edge. The bit clears itself.

A receive-ready output is derived from two bank registers: the receive control word and the receive length word. Reads through either port are combinational, so the read data belongs to the address presented in the same cycle. Writes take effect on the clock edge that ends the write cycle.

Top module: `ioreg_window`

## Requirements
- R1: The address port is at byte offset 0x00 and the data port at byte offset 0x04 of the 6-bit `io_addr`.
- R2: A full write to the address port stores `io_wdata[19:0]`. A read of the address port returns `{12'b0, stored offset}` in the same cycle.
- R3: The bank word used by the data port is stored-offset bits [16:2]. Offset bits [19:17] and [1:0] have no effect on the selection.
- R4: A data-port write changes only the writable bits of the selected word. The map, by word index:
  - Index 0 is control, with writable and readable mask 0xFBFFFFFF.
  - Index 1 is read-only status.
  - Index 2 is receive control, fully writable.
  - Index 3 is receive length, with writable and readable mask 0x000FFF80.
  - Indices 4..15 are fully writable.
  - Indices 16..23 are read-only.
  - Indices 24..63, and every index of 64 or more, are absent and ignore writes.
- R5: A data-port read of an absent index returns 0. A read at any offset other than 0x00 or 0x04 returns 0, and a write there changes nothing.
- R6: A write with `io_be` other than 4'hF has no effect on either port.
- R7: A data-port write to index 0 with bit 26 set does all of the following at that clock edge:
  - It reloads every word with its default.
  - It stores the written value with bit 26 cleared into index 0.
  - Bit 26 of index 0 always reads 0.
- R8: The soft reset of R7 also clears the stored offset to 0.
- R9: `rx_ready` is 1 exactly when bit 1 of index 2 is 1 and index 3 is nonzero.
- R10: The state after `rst_n` is low:
  - The stored offset is 0.
  - Index 0 holds 0x00000240.
  - Index 1 holds 0x00000080.
  - Index 16+k holds 0xC0DE0000+k for k in 0..7.
  - All other words hold 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 6 | Byte offset within the I/O region |
| io_wr | input | 1 | Write strobe for this cycle |
| io_be | input | 4 | Byte enables of the write |
| io_wdata | input | 32 | Write data |
| io_rdata | output | 32 | Read data for the current `io_addr` |
| rx_ready | output | 1 | Receive enabled and receive length nonzero |

## Verification
Bad state in the stored offset shows up on an address-port read in the first cycle after the write that caused it. It also sends every later data access to the wrong word. A wrong access mask or default shows on the data port in the same cycle as the read, because the read path has no register. A soft reset that is missed, late, or too broad shows one cycle after the control write. It appears as a stored offset that is not zero, a control value that has lost its written bits, or `rx_ready` staying high.

// File: rtl/ioreg_pkg.sv
package ioreg_pkg;
    localparam int IO_AW     = 6;
    localparam int DATA_W    = 32;
    localparam int LATCH_W   = 20;
    localparam int IDX_LSB   = 2;
    localparam int IDX_MSB   = 16;
    localparam int IDX_W     = IDX_MSB - IDX_LSB + 1;
    localparam logic [IO_AW-1:0] ADDR_PORT_OFS = 6'h00;
    localparam logic [IO_AW-1:0] DATA_PORT_OFS = 6'h04;

    localparam int CTRL_IDX   = 0;
    localparam int STATUS_IDX = 1;
    localparam int RXCTL_IDX  = 2;
    localparam int RXLEN_IDX  = 3;
    localparam int GEN_LO     = 4;
    localparam int GEN_HI     = 15;
    localparam int ID_LO      = 16;
    localparam int ID_HI      = 23;
    localparam int SRST_BIT   = 26;
    localparam int RXEN_BIT   = 1;

    typedef enum logic [1:0] {PORT_NONE, PORT_ADDR, PORT_DATA} port_sel_e;

    function automatic logic [DATA_W-1:0] word_wmask(int i);
        if (i == CTRL_IDX)                  return 32'hFBFF_FFFF;
        else if (i == RXCTL_IDX)            return 32'hFFFF_FFFF;
        else if (i == RXLEN_IDX)            return 32'h000F_FF80;
        else if (i >= GEN_LO && i <= GEN_HI) return 32'hFFFF_FFFF;
        else                                return 32'h0;
    endfunction

    function automatic logic [DATA_W-1:0] word_rmask(int i);
        if (i == CTRL_IDX)                  return 32'hFBFF_FFFF;
        else if (i == RXLEN_IDX)            return 32'h000F_FF80;
        else if (i >= STATUS_IDX && i <= ID_HI) return 32'hFFFF_FFFF;
        else                                return 32'h0;
    endfunction

    function automatic logic [DATA_W-1:0] word_default(int i);
        if (i == CTRL_IDX)                  return 32'h0000_0240;
        else if (i == STATUS_IDX)           return 32'h0000_0080;
        else if (i >= ID_LO && i <= ID_HI)  return 32'hC0DE_0000 | DATA_W'(i - ID_LO);
        else                                return 32'h0;
    endfunction
endpackage

// File: rtl/ioreg_port_decode.sv
module ioreg_port_decode
    import ioreg_pkg::*;
(
    input  logic [IO_AW-1:0] io_addr,
    input  logic             io_wr,
    input  logic [3:0]       io_be,
    output port_sel_e        sel,
    output logic             full_wr
);
    always_comb begin
        if (io_addr == ADDR_PORT_OFS)      sel = PORT_ADDR;
        else if (io_addr == DATA_PORT_OFS) sel = PORT_DATA;
        else                               sel = PORT_NONE;
        full_wr = io_wr && (io_be == 4'hF);
    end
endmodule

// File: rtl/ioreg_addr_latch.sv
module ioreg_addr_latch
    import ioreg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               soft_rst,
    output logic [LATCH_W-1:0] latch_q
);
    typedef struct packed {
        logic [LATCH_W-1:0] ofs;
    } latch_t;

    latch_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (soft_rst)   st_d.ofs = '0;
        else if (wr_en) st_d.ofs = wr_data[LATCH_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign latch_q = st_q.ofs;

    assert_addr_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !soft_rst) |=> (latch_q == $past(wr_data[LATCH_W-1:0])));
endmodule

// File: rtl/ioreg_bank.sv
module ioreg_bank
    import ioreg_pkg::*;
#(
    parameter int NUM_WORDS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              soft_rst,
    output logic              rx_ready
);
    localparam logic [DATA_W-1:0] SRST_MASK = DATA_W'(1) << SRST_BIT;

    typedef struct packed {
        logic [NUM_WORDS-1:0][DATA_W-1:0] words;
    } bank_t;

    function automatic bank_t reset_bank();
        bank_t b;
        for (int i = 0; i < NUM_WORDS; i++) b.words[i] = word_default(i);
        return b;
    endfunction

    localparam bank_t RESET_VAL = reset_bank();

    bank_t bank_d, bank_q;

    assign soft_rst = wr_en && (idx == IDX_W'(CTRL_IDX)) && wr_data[SRST_BIT];

    always_comb begin
        bank_d = bank_q;
        if (soft_rst) begin
            bank_d = RESET_VAL;
            bank_d.words[CTRL_IDX] = wr_data & ~SRST_MASK & word_wmask(CTRL_IDX);
        end else if (wr_en) begin
            for (int i = 0; i < NUM_WORDS; i++) begin
                if (idx == IDX_W'(i))
                    bank_d.words[i] = (bank_q.words[i] & ~word_wmask(i))
                                    | (wr_data & word_wmask(i));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= RESET_VAL;
        else        bank_q <= bank_d;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_WORDS; i++) begin
            if (idx == IDX_W'(i)) rd_data = bank_q.words[i] & word_rmask(i);
        end
    end

    assign rx_ready = bank_q.words[RXCTL_IDX][RXEN_BIT]
                   && (bank_q.words[RXLEN_IDX] != '0);

    assert_ctrl_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (bank_q.words[CTRL_IDX] == ($past(wr_data) & 32'hFBFF_FFFF)));

    assert_rx_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (bank_q.words[RXCTL_IDX] == '0 && bank_q.words[RXLEN_IDX] == '0));
endmodule

// File: rtl/ioreg_window.sv
module ioreg_window
    import ioreg_pkg::*;
#(
    parameter int NUM_WORDS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [5:0]        io_addr,
    input  logic              io_wr,
    input  logic [3:0]        io_be,
    input  logic [31:0]       io_wdata,
    output logic [31:0]       io_rdata,
    output logic              rx_ready
);
    port_sel_e          sel;
    logic               full_wr;
    logic               addr_wr;
    logic               data_wr;
    logic               soft_rst;
    logic [LATCH_W-1:0] latch_q;
    logic [DATA_W-1:0]  bank_rd;

    ioreg_port_decode u_dec (
        .io_addr (io_addr),
        .io_wr   (io_wr),
        .io_be   (io_be),
        .sel     (sel),
        .full_wr (full_wr)
    );

    assign addr_wr = full_wr && (sel == PORT_ADDR);
    assign data_wr = full_wr && (sel == PORT_DATA);

    ioreg_addr_latch u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (addr_wr),
        .wr_data  (io_wdata),
        .soft_rst (soft_rst),
        .latch_q  (latch_q)
    );

    ioreg_bank #(.NUM_WORDS(NUM_WORDS)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (data_wr),
        .idx      (latch_q[IDX_MSB:IDX_LSB]),
        .wr_data  (io_wdata),
        .rd_data  (bank_rd),
        .soft_rst (soft_rst),
        .rx_ready (rx_ready)
    );

    always_comb begin
        case (sel)
            PORT_ADDR: io_rdata = {{(DATA_W-LATCH_W){1'b0}}, latch_q};
            PORT_DATA: io_rdata = bank_rd;
            default:   io_rdata = '0;
        endcase
    end

    assert_unknown_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (io_addr != 6'h00 && io_addr != 6'h04) |-> (io_rdata == 32'h0));

    assert_partial_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_be != 4'hF) |=> $stable(latch_q));

    assert_srst_clears_ofs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (latch_q == '0));

    assert_rx_rise_on_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ready) |-> $past(data_wr));
endmodule

// File: tb/ioreg_window_test.sv
`timescale 1ns/1ps
module ioreg_window_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  io_addr = '0;
    logic        io_wr = 1'b0;
    logic [3:0]  io_be = '0;
    logic [31:0] io_wdata = '0;
    logic [31:0] io_rdata;
    logic        rx_ready;

    int checks = 0;
    int fails = 0;
    logic [31:0] model [0:63];
    logic [31:0] rd;

    always #2.5 clk = ~clk;

    ioreg_window uut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
        .io_be(io_be), .io_wdata(io_wdata), .io_rdata(io_rdata), .rx_ready(rx_ready)
    );

    function automatic logic [31:0] exp_wm(int i);
        if (i == 0) return 32'hFBFF_FFFF;
        if (i == 2) return 32'hFFFF_FFFF;
        if (i == 3) return 32'h000F_FF80;
        if (i >= 4 && i <= 15) return 32'hFFFF_FFFF;
        return 32'h0;
    endfunction

    function automatic logic [31:0] exp_rm(int i);
        if (i == 0) return 32'hFBFF_FFFF;
        if (i == 3) return 32'h000F_FF80;
        if (i >= 1 && i <= 23) return 32'hFFFF_FFFF;
        return 32'h0;
    endfunction

    function automatic logic [31:0] exp_def(int i);
        if (i == 0) return 32'h0000_0240;
        if (i == 1) return 32'h0000_0080;
        if (i >= 16 && i <= 23) return 32'hC0DE_0000 + 32'(i - 16);
        return 32'h0;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic io_write(logic [5:0] a, logic [3:0] be, logic [31:0] d);
        @(negedge clk);
        io_addr = a; io_be = be; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0; io_be = '0;
    endtask

    task automatic io_read(logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        io_addr = a; io_wr = 1'b0;
        #1;
        d = io_rdata;
    endtask

    task automatic sel_word(int i);
        io_write(6'h00, 4'hF, 32'(i) << 2);
    endtask

    task automatic model_write(int i, logic [31:0] d);
        sel_word(i);
        io_write(6'h04, 4'hF, d);
        if (i < 64) model[i] = (model[i] & ~exp_wm(i)) | (d & exp_wm(i));
    endtask

    task automatic check_word(string req, int i);
        logic [31:0] r;
        sel_word(i);
        io_read(6'h04, r);
        check(req, r, (i < 64) ? (model[i] & exp_rm(i)) : 32'h0);
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog actual=%08h expected=%08h", 32'h1, 32'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) model[i] = exp_def(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state
        io_read(6'h00, rd);
        check("R10 offset", rd, 32'h0);
        check("R10 rx_ready", {31'b0, rx_ready}, 32'h0);

        // R10 R4 R5: default sweep, with absent indices beyond the bank
        for (int i = 0; i < 64; i++) check_word("R10 default", i);
        check_word("R5 absent 64", 64);
        check_word("R5 absent 127", 127);

        // R4: write sweeps with two patterns (bit 26 clear for index 0)
        for (int i = 0; i < 64; i++) begin
            model_write(i, (i == 0) ? 32'hFBFF_FFFF : 32'hFFFF_FFFF);
            check_word("R4 ones", i);
        end
        for (int i = 0; i < 64; i++) begin
            model_write(i, 32'h5A5A_A5A5);
            check_word("R4 pattern", i);
        end

        // R4 R5: a write to an absent index must not alias into the bank
        model_write(64, 32'h1234_5678);
        check_word("R5 no alias idx0", 0);
        model_write(100, 32'h0);
        check_word("R5 no alias idx4", 4);

        // R2 R3: upper offset bits stored, but ignored for selection
        io_write(6'h00, 4'hF, 32'hFFFE_000B);
        io_read(6'h00, rd);
        check("R2 offset 20 bits", rd, 32'h000E_000B);
        io_read(6'h04, rd);
        check("R3 alias index 2", rd, model[2]);

        // R6: partial writes to either port change nothing
        io_write(6'h00, 4'h7, 32'h0000_0010);
        io_read(6'h00, rd);
        check("R6 addr partial", rd, 32'h000E_000B);
        io_write(6'h04, 4'h3, 32'h0);
        io_read(6'h04, rd);
        check("R6 data partial", rd, model[2]);

        // R1 R5: unrecognised offsets
        io_read(6'h08, rd);
        check("R5 read 0x08", rd, 32'h0);
        io_read(6'h3C, rd);
        check("R5 read 0x3C", rd, 32'h0);
        io_write(6'h08, 4'hF, 32'h1234_5678);
        io_read(6'h00, rd);
        check("R1 offset kept", rd, 32'h000E_000B);
        io_read(6'h04, rd);
        check("R1 data kept", rd, model[2]);

        // R9: receive-ready combinations
        model_write(2, 32'h0); model_write(3, 32'h0);
        check("R9 both off", {31'b0, rx_ready}, 32'h0);
        model_write(2, 32'h2);
        check("R9 len zero", {31'b0, rx_ready}, 32'h0);
        model_write(3, 32'h80);
        check("R9 ready", {31'b0, rx_ready}, 32'h1);
        model_write(3, 32'h7F);
        check("R9 masked len", {31'b0, rx_ready}, 32'h0);
        model_write(3, 32'h100); model_write(2, 32'h0);
        check("R9 enable off", {31'b0, rx_ready}, 32'h0);
        model_write(2, 32'h2);
        check("R9 ready again", {31'b0, rx_ready}, 32'h1);

        // R7 R8: soft reset via index 0 bit 26
        model_write(4, 32'hDEAD_BEEF);
        sel_word(0);
        io_write(6'h04, 4'hF, 32'h0400_0013);
        for (int i = 0; i < 64; i++) model[i] = exp_def(i);
        model[0] = 32'h0000_0013;
        check("R7 rx_ready cleared", {31'b0, rx_ready}, 32'h0);
        io_read(6'h00, rd);
        check("R8 offset cleared", rd, 32'h0);
        io_read(6'h04, rd);
        check("R7 ctrl kept, bit26 clear", rd, 32'h0000_0013);
        check_word("R7 general default", 4);
        check_word("R7 rxlen default", 3);
        check_word("R7 status", 1);
        check_word("R7 id", 16);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule